// File: doc/BRIEF.md
# EEPROM master arbitration sequencer

This block sequences the addressing side of an I2C EEPROM master that shares its two-wire bus with a second master. A command chooses one of two sequences. A plain addressing pass sends the device control byte once and reports whether the EEPROM acknowledged it. A write-completion poll repeats START, control byte (write direction) and acknowledge check until the EEPROM answers. The clock generator and the data phase sit outside the block. The block sees SCL only as a one-cycle strobe at the point where SCL is high and SDA must be sampled. It drives SDA open-drain style (1 means released) and asks the clock generator for START and STOP conditions with one-cycle request pulses.

Every transmitted bit is checked against the wired-AND line. When the block loses to the other master, it lets go of SDA for the rest of that byte, waits until a bus monitor reports the bus free, and starts the same sequence again from its first bit. One overall timeout window covers the whole command. An addressing pass gives up as soon as the window has run out while it waits for the bus. A poll sequence keeps going instead. A lost poll does not restart the window, and after expiry exactly one more completed poll decides the result.

Top module: `eeprom_arb_seq`

## Requirements
- R1: While reset is asserted and after it is released, sda_out is 1 and gen_start, gen_stop, done, ack_ok and timeout_flag are 0.
- R2: A command accepted in idle waits while bus_busy is 1. It gives a one-cycle gen_start in the cycle after bus_busy is seen 0, then shifts out the control byte {4'b1010, cmd_addr[2:0], direction}, MSB first. The direction bit is cmd_rw for an addressing pass and always 0 for a poll. sda_out shows the next bit from the cycle after each scl_stb and holds it between strobes.
- R3: When an scl_stb arrives during the control byte while sda_out is 1 and sda_in is 0, arbitration is lost. sda_out then stays 1 for the rest of that byte and through its acknowledge slot.
- R4: No arbitration comparison is made in the acknowledge slot. A 0 on sda_in there is read as ACK and never as a loss.
- R5: After a loss in an addressing pass, the block returns to waiting at the acknowledge-slot strobe and issues a new gen_start once the bus is free. It then sends the whole byte again from its MSB.
- R6: After a loss in a poll, the poll restarts the same way, and the timeout window is not restarted by the loss.
- R7: An addressing pass ends at its acknowledge strobe with a one-cycle done pulse. ack_ok is 1 if sda_in was 0 (ACK) at that strobe. ack_ok and timeout_flag hold until the next accepted command, which clears them.
- R8: In a poll, an ACK ends the command with done and ack_ok = 1. A NACK gives a one-cycle gen_stop and another poll.
- R9: The timeout window expires TIMEOUT_TICKS × TICK_DIV clock cycles after the command is accepted. In a poll, expiry never aborts a wait for the bus. The next completed poll is final: a NACK there gives gen_stop and done with timeout_flag = 1 and ack_ok = 0, and an ACK gives a normal success.
- R10: An addressing pass still waiting for the bus when the window expires ends with done, timeout_flag = 1 and ack_ok = 0, and it issues no gen_start.
- R11: cmd_start is ignored unless the block is idle. The running sequence, its control byte and its mode are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a command (accepted in idle only) |
| cmd_poll | input | 1 | 1 selects a poll sequence, 0 a single addressing pass |
| cmd_addr | input | ADDR_W | Device select bits placed in the control byte |
| cmd_rw | input | 1 | Direction bit for an addressing pass |
| bus_busy | input | 1 | Bus monitor reports the bus as taken |
| scl_stb | input | 1 | One-cycle strobe at the SCL-high sample point |
| sda_in | input | 1 | SDA line value as read back |
| sda_out | output | 1 | SDA drive value, 1 releases the line |
| gen_start | output | 1 | Request for a START condition |
| gen_stop | output | 1 | Request for a STOP condition |
| done | output | 1 | Command finished (one cycle) |
| ack_ok | output | 1 | Command ended with an acknowledged control byte |
| timeout_flag | output | 1 | Command ended because the timeout window ran out |

## Verification
A wrong internal state shows first on sda_out. A bad shift position or a missed loss changes the driven bit one cycle after the strobe that caused it, so the per-cycle comparison catches it within one bit slot. A wrong restart decision shows as a missing or extra gen_start or gen_stop pulse within a cycle or two after the acknowledge slot. A timeout window that is reset or mis-counted stays hidden until the final poll, where timeout_flag and done differ from the model about one frame later. For this reason the bench places a lost poll so that continuous and restarted windows give different outcomes.

// File: rtl/eepa_pkg.sv
package eepa_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_SEND = 2'd2,
      SEQ_ACK  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/eepa_timeout.sv
module eepa_timeout #(
   parameter int TICKS = 60000,
   parameter int DIV   = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int TW = $clog2(TICKS + 1);

   if (TICKS < 2) begin : g_bad_ticks
      $error("eepa_timeout: TICKS must be at least 2");
   end
   if (DIV < 1) begin : g_bad_div
      $error("eepa_timeout: DIV must be at least 1");
   end

   logic          step;
   logic [TW-1:0] ticks_q;
   logic          exp_q;

   // the window is either counted directly or through a prescaler
   if (DIV == 1) begin : g_direct
      assign step = run && !exp_q;
   end else begin : g_prescale
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   pre_q <= '0;
         else if (clear)               pre_q <= '0;
         else if (run && !exp_q) begin
            if (pre_q == PW'(DIV - 1)) pre_q <= '0;
            else                       pre_q <= pre_q + 1'b1;
         end
      end
      assign step = run && !exp_q && (pre_q == PW'(DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
         exp_q   <= 1'b0;
      end else if (clear) begin
         ticks_q <= '0;
         exp_q   <= 1'b0;
      end else if (step) begin
         ticks_q <= ticks_q + 1'b1;
         if (ticks_q == TW'(TICKS - 1)) exp_q <= 1'b1;
      end
   end

   assign expired = exp_q;

   // R9: once expired the window stays expired until a new command clears it
   a_r9_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_q && !clear) |=> exp_q);
   // R9: the tick count never passes the window length
   a_r9_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ticks_q <= TW'(TICKS));
endmodule

// File: rtl/eepa_tx_arb.sv
module eepa_tx_arb #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              active,
   input  logic              scl_stb,
   input  logic              sda_in,
   output logic              sda_drv,
   output logic              last_bit,
   output logic              lost
);
   localparam int IW = $clog2(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_width
      $error("eepa_tx_arb: BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] sh_q;
   logic [IW-1:0]     idx_q;
   logic              lost_q;

   // after a loss the line is only released, never driven low
   assign sda_drv  = active ? (lost_q | sh_q[BYTE_W-1]) : 1'b1;
   assign last_bit = (idx_q == IW'(BYTE_W - 1));
   assign lost     = lost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         idx_q  <= '0;
         lost_q <= 1'b0;
      end else if (load) begin
         sh_q   <= byte_in;
         idx_q  <= '0;
         lost_q <= 1'b0;
      end else if (active && scl_stb) begin
         sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
         idx_q <= idx_q + 1'b1;
         if (sda_drv && !sda_in) lost_q <= 1'b1;
      end
   end

   // R3: a loss is only ever recorded from a released bit read back low
   a_r3_loss_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_q) |-> $past(active && scl_stb && sda_drv && !sda_in));
   // R4: outside the control byte nothing alters the loss record
   a_r4_no_compare_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> $stable(lost_q));
endmodule

// File: rtl/eeprom_arb_seq.sv
module eeprom_arb_seq #(
   parameter int              CODE_W        = 4,
   parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1010,
   parameter int              ADDR_W        = 3,
   parameter int              TIMEOUT_TICKS = 60000,
   parameter int              TICK_DIV      = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_poll,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_rw,
   input  logic              bus_busy,
   input  logic              scl_stb,
   input  logic              sda_in,
   output logic              sda_out,
   output logic              gen_start,
   output logic              gen_stop,
   output logic              done,
   output logic              ack_ok,
   output logic              timeout_flag
);
   import eepa_pkg::*;

   localparam int BYTE_W = CODE_W + ADDR_W + 1;

   if (CODE_W < 1 || ADDR_W < 1) begin : g_bad_fields
      $error("eeprom_arb_seq: CODE_W and ADDR_W must be at least 1");
   end

   seq_state_e        st_q;
   logic              poll_q;
   logic [BYTE_W-1:0] ctrl_q;
   logic              done_q, ack_q, to_q, gs_q, gp_q;

   logic accept, abort_wait, load, expired;
   logic sda_drv, last_bit, lost;

   assign accept     = (st_q == SEQ_IDLE) && cmd_start;
   assign abort_wait = (st_q == SEQ_WAIT) && !poll_q && expired;
   assign load       = (st_q == SEQ_WAIT) && !abort_wait && !bus_busy;

   eepa_timeout #(.TICKS(TIMEOUT_TICKS), .DIV(TICK_DIV)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .run     (st_q != SEQ_IDLE),
      .expired (expired)
   );

   eepa_tx_arb #(.BYTE_W(BYTE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .byte_in  (ctrl_q),
      .active   (st_q == SEQ_SEND),
      .scl_stb  (scl_stb),
      .sda_in   (sda_in),
      .sda_drv  (sda_drv),
      .last_bit (last_bit),
      .lost     (lost)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         poll_q <= 1'b0;
         ctrl_q <= '0;
         done_q <= 1'b0;
         ack_q  <= 1'b0;
         to_q   <= 1'b0;
         gs_q   <= 1'b0;
         gp_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         gs_q   <= 1'b0;
         gp_q   <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: if (cmd_start) begin
               poll_q <= cmd_poll;
               ctrl_q <= {DEV_CODE, cmd_addr, cmd_poll ? 1'b0 : cmd_rw};
               ack_q  <= 1'b0;
               to_q   <= 1'b0;
               st_q   <= SEQ_WAIT;
            end
            SEQ_WAIT: if (abort_wait) begin
               done_q <= 1'b1;
               to_q   <= 1'b1;
               st_q   <= SEQ_IDLE;
            end else if (!bus_busy) begin
               gs_q <= 1'b1;
               st_q <= SEQ_SEND;
            end
            SEQ_SEND: if (scl_stb && last_bit) st_q <= SEQ_ACK;
            SEQ_ACK: if (scl_stb) begin
               if (lost) begin
                  st_q <= SEQ_WAIT;               // restart the same sequence
               end else if (!poll_q) begin
                  done_q <= 1'b1;
                  ack_q  <= !sda_in;
                  st_q   <= SEQ_IDLE;
               end else if (!sda_in) begin
                  done_q <= 1'b1;
                  ack_q  <= 1'b1;
                  st_q   <= SEQ_IDLE;
               end else begin
                  gp_q <= 1'b1;
                  if (expired) begin              // that was the final poll
                     done_q <= 1'b1;
                     to_q   <= 1'b1;
                     st_q   <= SEQ_IDLE;
                  end else begin
                     st_q <= SEQ_WAIT;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign sda_out      = sda_drv;
   assign gen_start    = gs_q;
   assign gen_stop     = gp_q;
   assign done         = done_q;
   assign ack_ok       = ack_q;
   assign timeout_flag = to_q;

   // R2: a START request only follows a cycle with the bus free
   a_r2_start_on_free: assert property (@(posedge clk) disable iff (!rst_n)
      gen_start |-> $past(!bus_busy));
   // R2: the driven bit holds between strobes during the control byte
   a_r2_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_SEND && !scl_stb) |=> $stable(sda_out));
   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: a poll ending on timeout always asks for STOP in the same cycle
   a_r9_final_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (done && timeout_flag && poll_q) |-> gen_stop);
   // R10: a timed-out command never reports an acknowledge
   a_r10_timeout_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_flag |-> !ack_ok);
   // R11: a start request outside idle leaves the control byte alone
   a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != SEQ_IDLE) |=> $stable(ctrl_q));
endmodule

// File: tb/eeprom_arb_seq_test.sv
module eeprom_arb_seq_test;
   localparam int TICKS = 20;
   localparam int DIV   = 4;
   localparam int LIMIT = TICKS * DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0, cmd_poll = 1'b0, cmd_rw = 1'b0;
   logic [2:0] cmd_addr = 3'd0;
   logic       bus_busy = 1'b0, scl_stb = 1'b0;
   logic       oth_sda = 1'b1, slv_sda = 1'b1;
   logic       sda_in_w;
   logic       sda_out, gen_start, gen_stop, done, ack_ok, timeout_flag;

   always #2.5 clk = ~clk;   // 200 MHz

   assign sda_in_w = sda_out & oth_sda & slv_sda;

   eeprom_arb_seq #(.TIMEOUT_TICKS(TICKS), .TICK_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_poll(cmd_poll),
      .cmd_addr(cmd_addr), .cmd_rw(cmd_rw), .bus_busy(bus_busy),
      .scl_stb(scl_stb), .sda_in(sda_in_w), .sda_out(sda_out),
      .gen_start(gen_start), .gen_stop(gen_stop), .done(done),
      .ack_ok(ack_ok), .timeout_flag(timeout_flag)
   );

   // ---------------- behavioural reference model ----------------
   // phase: 0 idle, 1 waiting for bus, 2 sending byte, 3 ack slot
   int         m_phase = 0, m_bit = 0, m_cnt = 0;
   bit         m_lost = 0, m_poll = 0, m_exp = 0;
   bit         m_done = 0, m_ack = 0, m_to = 0, m_gs = 0, m_gp = 0;
   logic [7:0] m_byte = 8'h00;

   function automatic bit m_sda();
      if (m_phase == 2 && !m_lost) return m_byte[7 - m_bit];
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      bit old_exp;
      bit drv;
      if (!rst_n) begin
         m_phase = 0; m_bit = 0; m_cnt = 0; m_lost = 0; m_poll = 0; m_exp = 0;
         m_done = 0; m_ack = 0; m_to = 0; m_gs = 0; m_gp = 0; m_byte = 8'h00;
      end else begin
         old_exp = m_exp;
         drv = m_sda();
         m_done = 0; m_gs = 0; m_gp = 0;
         if (m_phase != 0 && !m_exp) begin
            m_cnt++;
            if (m_cnt == LIMIT) m_exp = 1;
         end
         case (m_phase)
            0: if (cmd_start) begin
               m_poll = cmd_poll;
               m_byte = {4'b1010, cmd_addr, cmd_poll ? 1'b0 : cmd_rw};
               m_cnt = 0; m_exp = 0; m_ack = 0; m_to = 0; m_phase = 1;
            end
            1: if (!m_poll && old_exp) begin
               m_done = 1; m_to = 1; m_phase = 0;
            end else if (!bus_busy) begin
               m_gs = 1; m_phase = 2; m_bit = 0; m_lost = 0;
            end
            2: if (scl_stb) begin
               if (drv && !sda_in_w) m_lost = 1;
               if (m_bit == 7) m_phase = 3; else m_bit++;
            end
            default: if (scl_stb) begin
               if (m_lost) m_phase = 1;
               else if (!m_poll) begin
                  m_done = 1; m_ack = !sda_in_w; m_phase = 0;
               end else if (!sda_in_w) begin
                  m_done = 1; m_ack = 1; m_phase = 0;
               end else begin
                  m_gp = 1;
                  if (old_exp) begin m_done = 1; m_to = 1; m_phase = 0; end
                  else m_phase = 1;
               end
            end
         endcase
      end
   end

   // ---------------- per-cycle comparison ----------------
   int  mon_checks = 0, mon_fails = 0;
   int  gs_cnt = 0, gp_cnt = 0, done_cnt = 0;
   bit  mon_en = 0;

   task automatic mchk(input bit ok, input string what, input int act, input int exp);
      mon_checks++;
      if (!ok) begin
         mon_fails++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         mchk(sda_out === m_sda(), "R2/R3 sda_out", sda_out, m_sda());
         mchk(gen_start === m_gs, "R5 gen_start", gen_start, m_gs);
         mchk(gen_stop === m_gp, "R8 gen_stop", gen_stop, m_gp);
         mchk(done === m_done, "R7 done", done, m_done);
         mchk(ack_ok === m_ack, "R7 ack_ok", ack_ok, m_ack);
         mchk(timeout_flag === m_to, "R9 timeout_flag", timeout_flag, m_to);
         if (gen_start) gs_cnt++;
         if (gen_stop)  gp_cnt++;
         if (done)      done_cnt++;
      end
   end

   // ---------------- scenario checks ----------------
   int  sc_checks = 0, sc_fails = 0;
   bit  finished = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      sc_checks++;
      if (!ok) begin
         sc_fails++;
         $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(input bit poll, input logic [2:0] addr, input bit rw);
      cmd_poll = poll; cmd_addr = addr; cmd_rw = rw; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic slot(input logic o, input logic s);
      oth_sda = o; slv_sda = s;
      @(negedge clk);
      scl_stb = 1'b1;
      @(negedge clk);
      scl_stb = 1'b0; oth_sda = 1'b1; slv_sda = 1'b1;
   endtask

   // eight control bits against another master's byte, then the ack slot
   task automatic frame(input logic [7:0] oth, input bit ack);
      for (int i = 7; i >= 0; i--) slot(oth[i], 1'b1);
      slot(1'b1, ~ack);
   endtask

   initial begin
      int b_gs, b_gp, b_done;
      wait_n(1);
      mon_en = 1;
      wait_n(2);
      chk(sda_out === 1'b1 && done === 1'b0 && gen_start === 1'b0, "R1 reset outputs",
          {sda_out, done, gen_start}, 3'b100);
      rst_n = 1'b1;
      wait_n(2);
      chk(ack_ok === 1'b0 && timeout_flag === 1'b0, "R1 idle flags",
          {ack_ok, timeout_flag}, 0);

      // addressing pass, no contention, ACK
      issue(0, 3'b101, 1); wait_n(2);
      frame(8'hFF, 1); wait_n(2);
      chk(ack_ok === 1'b1 && timeout_flag === 1'b0, "R7 addressing ACK", ack_ok, 1);

      // addressing pass NACK
      issue(0, 3'b010, 0); wait_n(2);
      frame(8'hFF, 0); wait_n(2);
      chk(ack_ok === 1'b0, "R7 addressing NACK", ack_ok, 0);

      // addressing pass loses to 1010_000_0, restarts after bus frees
      b_gs = gs_cnt;
      issue(0, 3'b101, 1); wait_n(2);
      bus_busy = 1'b1;
      frame(8'b1010_0000, 1); wait_n(10);
      chk(gs_cnt - b_gs == 1, "R5 no restart while busy", gs_cnt - b_gs, 1);
      bus_busy = 1'b0; wait_n(2);
      chk(gs_cnt - b_gs == 2, "R5 restart START issued", gs_cnt - b_gs, 2);
      frame(8'hFF, 1); wait_n(2);
      chk(ack_ok === 1'b1, "R5 restarted pass ACK", ack_ok, 1);
      chk(ack_ok === 1'b1, "R4 ack slot low is not a loss", ack_ok, 1);

      // poll: NACK, NACK, ACK (rw input ignored, R2)
      b_gp = gp_cnt;
      issue(1, 3'b011, 1); wait_n(2);
      frame(8'hFF, 0); wait_n(2);
      frame(8'hFF, 0); wait_n(2);
      frame(8'hFF, 1); wait_n(2);
      chk(gp_cnt - b_gp == 2, "R8 STOP per NACKed poll", gp_cnt - b_gp, 2);
      chk(ack_ok === 1'b1 && timeout_flag === 1'b0, "R8 poll success", ack_ok, 1);

      // poll lost, window keeps running across the restart
      b_done = done_cnt;
      issue(1, 3'b011, 0); wait_n(2);
      bus_busy = 1'b1;
      frame(8'b1010_0000, 1); wait_n(50);
      chk(done_cnt == b_done, "R6 lost poll does not end command", done_cnt - b_done, 0);
      bus_busy = 1'b0; wait_n(2);
      frame(8'hFF, 0); wait_n(2);
      chk(timeout_flag === 1'b1, "R6 window not restarted by loss", timeout_flag, 1);

      // poll expires while waiting, final poll ACKed
      b_done = done_cnt;
      bus_busy = 1'b1;
      issue(1, 3'b110, 0); wait_n(LIMIT + 20);
      chk(done_cnt == b_done, "R9 no abort while waiting in poll", done_cnt - b_done, 0);
      bus_busy = 1'b0; wait_n(2);
      frame(8'hFF, 1); wait_n(2);
      chk(ack_ok === 1'b1 && timeout_flag === 1'b0, "R9 final poll ACK succeeds",
          {ack_ok, timeout_flag}, 2);

      // poll expires while waiting, final poll NACKed
      b_gp = gp_cnt;
      bus_busy = 1'b1;
      issue(1, 3'b110, 0); wait_n(LIMIT + 20);
      bus_busy = 1'b0; wait_n(2);
      frame(8'hFF, 0); wait_n(2);
      chk(timeout_flag === 1'b1 && ack_ok === 1'b0, "R9 final poll NACK times out",
          {ack_ok, timeout_flag}, 1);
      chk(gp_cnt - b_gp == 1, "R9 final poll STOP", gp_cnt - b_gp, 1);

      // addressing pass expires while waiting
      b_gs = gs_cnt;
      bus_busy = 1'b1;
      issue(0, 3'b001, 1); wait_n(LIMIT + 10);
      chk(timeout_flag === 1'b1 && ack_ok === 1'b0, "R10 addressing timeout",
          {ack_ok, timeout_flag}, 1);
      chk(gs_cnt == b_gs, "R10 no START on timeout", gs_cnt - b_gs, 0);
      bus_busy = 1'b0; wait_n(2);

      // start request during a running pass is ignored
      b_gp = gp_cnt; b_done = done_cnt;
      issue(0, 3'b001, 0); wait_n(2);
      issue(1, 3'b111, 1);
      frame(8'hFF, 0); wait_n(2);
      chk(done_cnt - b_done == 1 && gp_cnt == b_gp, "R11 mode kept despite start",
          gp_cnt - b_gp, 0);
      chk(ack_ok === 1'b0 && timeout_flag === 1'b0, "R11 pass result", ack_ok, 0);

      finished = 1;
      $display("%0d/%0d checks passed", (sc_checks + mon_checks) - (sc_fails + mon_fails),
               sc_checks + mon_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed",
                  (sc_checks + mon_checks) - (sc_fails + mon_fails),
                  sc_checks + mon_checks + 1);
         $finish;
      end
   end
endmodule